// File: doc/BRIEF.md
# Pipelined Burst SRAM Front End

This block is a synchronous single-port SRAM with a pipelined command path that needs no idle cycle between a read and a write. On every active clock edge the command inputs carry one of five things: a new read, a new write, a continuation of the current burst, a deselect, or a stall (clock enable low). Read data comes back two clocks after its address. Write data is sampled two clocks after its address. Because both lag by the same amount, reads and writes can be interleaved at full rate.

Writes use a late-write scheme. Write data is first held in a pending write register. It enters the storage array only when the next write reaches the second pipeline stage, so each edge makes at most one array access. A read of an address whose newest bytes are still in the pending register gets those bytes merged in. A burst of four beats starts from a loaded address. The beats then cycle inside the aligned four-word group, in either linear or interleaved order. A low clock enable freezes every register in the block.

A burst controller tracks what the block is doing, using three named states:

- `S_IDLE`: deselected.
- `S_RD`: read burst.
- `S_WR`: write burst.

The transitions are:

- `LOAD_RD`: a selected load with the write request low enters `S_RD`.
- `LOAD_WR`: a selected load with the write request high enters `S_WR`.
- `LOAD_DESEL`: a load with the chip unselected enters `S_IDLE`.
- `ADVANCE`: the advance input high keeps the current state.
- `HOLD`: clock enable low keeps the current state.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is asserted and right after it, `rdata_en` is 0 and no command is in flight.
- R2: When a read is loaded at edge k, `rdata` holds the word from the logical memory after edge k+2, and `rdata_en` is 1 in that same cycle.
- R3: For a write loaded at edge k, `wdata` is sampled at active edge k+2. Byte enable bit i selects bits [8i+7:8i] of the word, and the byte enables are taken in the same cycle as each beat's address.
- R4: With `burst_ilv`=0, advance beat n of a burst from base b uses address {b[7:2], (b[1:0]+n) mod 4}. The upper address bits stay fixed and the low bits wrap within the group.
- R5: With `burst_ilv`=1, advance beat n uses address {b[7:2], b[1:0] XOR n}.
- R6: The chip is selected only when `cs_a_n`=0, `cs_b_n`=0 and `cs_c`=1. A load without selection is a no-op that leaves memory untouched, and later advance cycles also stay no-ops.
- R7: When `clk_en`=0, no register changes. No write happens, `wdata` is ignored, and `rdata`/`rdata_en` hold their values.
- R8: A read always returns the newest data, including bytes from a write whose data is still pending. Bytes that write did not enable keep their older contents.
- R9: `rdata_en` is 1 only in cycles that return read data. It is 0 two active clocks after a deselect that follows the last read.
- R10: Reads and writes may alternate on consecutive edges with no idle cycle, and each returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; 0 stalls the whole block |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b_n | input | 1 | Chip select, active low |
| cs_c | input | 1 | Chip select, active high |
| adv_ld | input | 1 | 0 loads a new address and command, 1 advances the burst |
| wr_req | input | 1 | On a load: 1 write, 0 read |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | 8 | Word address |
| byte_en | input | 4 | Per-byte write enables, active high |
| wdata | input | 32 | Write data, two clocks after its address |
| rdata | output | 32 | Read data |
| rdata_en | output | 1 | Output drive enable, high while read data is returned |

## Verification
Suppose the pending write register loses its valid flag or stores the wrong byte mask. The error then shows as a wrong byte in `rdata`. It appears in the first read to that address, which is two clocks after the read command, even though the array itself looks correct. Suppose instead the burst counter or burst state is corrupted. The second beat of the next burst then reads from the wrong word, visible two clocks later. A stall that leaks would show as `rdata` or `rdata_en` changing during the held cycle, or as a stalled `wdata` value reaching memory.

// File: rtl/sync_burst_sram_pkg.sv
package sync_burst_sram_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2
    } bstate_e;
endpackage

// File: rtl/sram_burst_ctrl.sv
module sram_burst_ctrl
    import sync_burst_sram_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NB        = 4,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          sel,
    input  logic          adv_ld,
    input  logic          wr_req,
    input  logic          burst_ilv,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] byte_en,
    output op_e           cmd_op,
    output logic [AW-1:0] cmd_addr,
    output logic [NB-1:0] cmd_be
);
    localparam int CW = $clog2(BURST_LEN);

    bstate_e       state, nxt;
    logic [AW-1:0] base;
    logic [CW-1:0] cnt;
    logic [CW-1:0] step_off;

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b,
                                                input logic [CW-1:0] off,
                                                input logic          ilv);
        logic [CW-1:0] lo;
        lo = ilv ? (b[CW-1:0] ^ off) : (b[CW-1:0] + off);
        return {b[AW-1:CW], lo};
    endfunction

    assign step_off = cnt + CW'(1);

    // Next-state logic
    always_comb begin
        nxt = state;
        if (!adv_ld) begin
            if (!sel)        nxt = S_IDLE;   // LOAD_DESEL
            else if (wr_req) nxt = S_WR;     // LOAD_WR
            else             nxt = S_RD;     // LOAD_RD
        end else begin
            unique case (state)              // ADVANCE
                S_IDLE:  nxt = S_IDLE;
                S_RD:    nxt = S_RD;
                S_WR:    nxt = S_WR;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // State register; HOLD when clock enable is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            base  <= '0;
            cnt   <= '0;
        end else if (clk_en) begin
            state <= nxt;
            if (!adv_ld) begin
                base <= addr;
                cnt  <= '0;
            end else if (state != S_IDLE) begin
                cnt <= step_off;
            end
        end
    end

    // Command outputs
    always_comb begin
        cmd_be = byte_en;
        if (!adv_ld) begin
            cmd_addr = addr;
            cmd_op   = !sel ? OP_NOP : (wr_req ? OP_WR : OP_RD);
        end else begin
            cmd_addr = beat_addr(base, step_off, burst_ilv);
            unique case (state)
                S_RD:    cmd_op = OP_RD;
                S_WR:    cmd_op = OP_WR;
                default: cmd_op = OP_NOP;
            endcase
        end
    end

    a_r7_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(state) && $stable(cnt) && $stable(base)));

    a_r6_desel_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && !sel) |=> (state == S_IDLE));

    a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && state != S_IDLE) |=> (cnt == CW'($past(cnt) + CW'(1))));
endmodule

// File: rtl/sram_array.sv
module sram_array #(
    parameter int DEPTH = 256,
    parameter int NB    = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [NB-1:0]            be,
    input  logic [8*NB-1:0]          wdata,
    output logic [8*NB-1:0]          rd_word
);
    localparam int DW = 8 * NB;

    logic [DW-1:0] mem [DEPTH];

    assign rd_word = mem[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < NB; i++) begin
                if (be[i]) mem[addr][8*i +: 8] <= wdata[8*i +: 8];
            end
        end
    end
endmodule

// File: rtl/sram_pipe.sv
module sram_pipe
    import sync_burst_sram_pkg::*;
#(
    parameter int AW = 8,
    parameter int NB = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  op_e              cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [NB-1:0]    cmd_be,
    input  logic [8*NB-1:0]  wdata,
    input  logic [8*NB-1:0]  arr_rd_word,
    output logic             arr_we,
    output logic [AW-1:0]    arr_addr,
    output logic [NB-1:0]    arr_be,
    output logic [8*NB-1:0]  arr_wdata,
    output logic [8*NB-1:0]  rdata,
    output logic             rdata_en
);
    localparam int DW = 8 * NB;

    op_e           s1_op, s2_op;
    logic [AW-1:0] s1_addr, s2_addr;
    logic [NB-1:0] s1_be, s2_be;

    logic          pend_v;
    logic [AW-1:0] pend_addr;
    logic [NB-1:0] pend_be;
    logic [DW-1:0] pend_data;

    logic          hit;
    logic [DW-1:0] fwd_word;

    // Single array port: commit pending write on a write beat, else read
    assign arr_we    = clk_en && (s2_op == OP_WR) && pend_v;
    assign arr_addr  = (s2_op == OP_WR) ? pend_addr : s2_addr;
    assign arr_be    = pend_be;
    assign arr_wdata = pend_data;

    assign hit = pend_v && (pend_addr == s2_addr);

    for (genvar g = 0; g < NB; g++) begin : g_fwd
        assign fwd_word[8*g +: 8] = (hit && pend_be[g]) ? pend_data[8*g +: 8]
                                                        : arr_rd_word[8*g +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op     <= OP_NOP;
            s2_op     <= OP_NOP;
            s1_addr   <= '0;
            s2_addr   <= '0;
            s1_be     <= '0;
            s2_be     <= '0;
            pend_v    <= 1'b0;
            pend_addr <= '0;
            pend_be   <= '0;
            pend_data <= '0;
            rdata     <= '0;
            rdata_en  <= 1'b0;
        end else if (clk_en) begin
            s1_op   <= cmd_op;
            s1_addr <= cmd_addr;
            s1_be   <= cmd_be;
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
            if (s2_op == OP_WR) begin
                pend_v    <= 1'b1;
                pend_addr <= s2_addr;
                pend_be   <= s2_be;
                pend_data <= wdata;
            end
            if (s2_op == OP_RD) rdata <= fwd_word;
            rdata_en <= (s2_op == OP_RD);
        end
    end

    a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(rdata) && $stable(rdata_en)));

    a_r8_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_op == OP_WR) |=> (pend_v && pend_addr == $past(s2_addr)));
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sync_burst_sram_pkg::*;
#(
    parameter int DEPTH     = 256,
    parameter int NB        = 4,
    parameter int BURST_LEN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     cs_a_n,
    input  logic                     cs_b_n,
    input  logic                     cs_c,
    input  logic                     adv_ld,
    input  logic                     wr_req,
    input  logic                     burst_ilv,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [NB-1:0]            byte_en,
    input  logic [8*NB-1:0]          wdata,
    output logic [8*NB-1:0]          rdata,
    output logic                     rdata_en
);
    localparam int AW = $clog2(DEPTH);
    localparam int DW = 8 * NB;

    logic          sel;
    op_e           cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [NB-1:0] cmd_be;
    logic          arr_we;
    logic [AW-1:0] arr_addr;
    logic [NB-1:0] arr_be;
    logic [DW-1:0] arr_wdata;
    logic [DW-1:0] arr_rd_word;

    assign sel = !cs_a_n && !cs_b_n && cs_c;

    sram_burst_ctrl #(.AW(AW), .NB(NB), .BURST_LEN(BURST_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(sel),
        .adv_ld(adv_ld), .wr_req(wr_req), .burst_ilv(burst_ilv),
        .addr(addr), .byte_en(byte_en),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_be(cmd_be)
    );

    sram_pipe #(.AW(AW), .NB(NB)) u_pipe (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
        .wdata(wdata), .arr_rd_word(arr_rd_word),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_be(arr_be),
        .arr_wdata(arr_wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    sram_array #(.DEPTH(DEPTH), .NB(NB)) u_array (
        .clk(clk), .we(arr_we), .addr(arr_addr), .be(arr_be),
        .wdata(arr_wdata), .rd_word(arr_rd_word)
    );

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rdata_en);
endmodule

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_cen = 1'b1, i_csa = 1'b1, i_csb = 1'b0, i_csc = 1'b1;
    logic        i_adv = 1'b0, i_wr = 1'b0, i_ilv = 1'b0;
    logic [7:0]  i_addr = '0;
    logic [3:0]  i_be = '0;
    logic [31:0] i_wdata = '0;
    logic [31:0] rdata;
    logic        rdata_en;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [31:0] mdl [256];
    logic [1:0]  bst = 0;
    logic [7:0]  bbase = 0;
    logic [1:0]  bcnt = 0;
    logic [1:0]  b1_op = 0, b2_op = 0;
    logic [7:0]  b1_addr = 0, b2_addr = 0;
    logic [3:0]  b1_be = 0, b2_be = 0;
    logic        exp_en = 0;
    logic [31:0] exp_data = 0;

    always #2 clk = ~clk;

    sync_burst_sram u_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(i_cen),
        .cs_a_n(i_csa), .cs_b_n(i_csb), .cs_c(i_csc),
        .adv_ld(i_adv), .wr_req(i_wr), .burst_ilv(i_ilv),
        .addr(i_addr), .byte_en(i_be), .wdata(i_wdata),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] beat(input logic [7:0] b, input logic [1:0] off, input logic ilv);
        return {b[7:2], ilv ? (b[1:0] ^ off) : (b[1:0] + off)};
    endfunction

    // One clock: expected behaviour from requirements, then check after edge
    task automatic tick(input string tag);
        logic sel;
        logic [1:0] op, off;
        logic [7:0] ca;
        sel = !i_csa && !i_csb && i_csc;
        off = bcnt + 2'd1;
        if (!i_adv) begin
            op = sel ? (i_wr ? 2'd2 : 2'd1) : 2'd0;
            ca = i_addr;
        end else begin
            op = bst;
            ca = beat(bbase, off, i_ilv);
        end
        i_wdata = $urandom;
        if (i_cen) begin
            if (b2_op == 2'd2)
                for (int i = 0; i < 4; i++)
                    if (b2_be[i]) mdl[b2_addr][8*i +: 8] = i_wdata[8*i +: 8];
            if (b2_op == 2'd1) begin
                exp_en = 1'b1;
                exp_data = mdl[b2_addr];
            end else begin
                exp_en = 1'b0;
            end
            b2_op = b1_op; b2_addr = b1_addr; b2_be = b1_be;
            b1_op = op;    b1_addr = ca;      b1_be = i_be;
            if (!i_adv) begin
                bst = op; bbase = i_addr; bcnt = 2'd0;
            end else if (bst != 2'd0) begin
                bcnt = off;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(rdata_en == exp_en, {tag, " rdata_en"}, {31'd0, rdata_en}, {31'd0, exp_en});
        if (exp_en) chk(rdata == exp_data, {tag, " rdata"}, rdata, exp_data);
    endtask

    task automatic load(input logic wr, input logic [7:0] a, input logic [3:0] be, input string tag);
        i_cen = 1; i_adv = 0; i_csa = 0; i_csb = 0; i_csc = 1;
        i_wr = wr; i_addr = a; i_be = be;
        tick(tag);
    endtask

    task automatic adv_cyc(input logic [3:0] be, input string tag);
        i_cen = 1; i_adv = 1; i_addr = $urandom; i_be = be; i_wr = $urandom;
        tick(tag);
    endtask

    task automatic desel(input string tag);
        i_cen = 1; i_adv = 0; i_csa = 1; i_addr = $urandom;
        tick(tag);
    endtask

    task automatic stall(input string tag);
        i_cen = 0; i_adv = $urandom; i_csa = $urandom; i_wr = $urandom;
        i_addr = $urandom; i_be = $urandom;
        tick(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk(rdata_en == 1'b0, "R1 in reset", {31'd0, rdata_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rdata_en == 1'b0, "R1 after reset", {31'd0, rdata_en}, 32'd0);

        // R3: fill whole array with full-word linear write bursts
        i_ilv = 0;
        for (int g = 0; g < 64; g++) begin
            load(1, 8'(g * 4), 4'hF, "R3");
            repeat (3) adv_cyc(4'hF, "R3");
        end
        repeat (3) desel("R9");

        // R2/R4: linear read burst from unaligned base, wraps in group
        load(0, 8'h11, 4'h0, "R2");
        repeat (3) adv_cyc(4'h0, "R4");
        load(0, 8'hA3, 4'h0, "R4");
        repeat (3) adv_cyc(4'h0, "R4");
        desel("R9"); desel("R9"); desel("R9");

        // R5: interleaved order
        i_ilv = 1;
        load(0, 8'h22, 4'h0, "R5");
        repeat (3) adv_cyc(4'h0, "R5");
        load(0, 8'h37, 4'h0, "R5");
        repeat (3) adv_cyc(4'h0, "R5");
        load(1, 8'h81, 4'hF, "R5");
        repeat (3) adv_cyc(4'h3, "R5");
        load(0, 8'h80, 4'h0, "R5");
        repeat (3) adv_cyc(4'h0, "R5");
        i_ilv = 0;
        repeat (3) desel("R9");

        // R8: reads right behind partial writes still pending
        load(1, 8'h40, 4'h5, "R8");
        load(0, 8'h40, 4'h0, "R8");
        load(1, 8'h40, 4'hA, "R8");
        load(0, 8'h40, 4'h0, "R8");
        load(0, 8'h41, 4'h0, "R8");
        load(1, 8'h41, 4'h2, "R8");
        load(1, 8'h42, 4'hF, "R8");
        load(0, 8'h41, 4'h0, "R8");
        load(0, 8'h40, 4'h0, "R8");
        repeat (3) desel("R9");

        // R10: strict read/write alternation
        for (int k = 0; k < 12; k++)
            load(k[0], 8'h50 + 8'(k / 2), 4'hF, "R10");
        repeat (3) desel("R10");

        // R7: stalls inside write and read bursts
        load(1, 8'h60, 4'hF, "R7");
        repeat (3) stall("R7");
        adv_cyc(4'hF, "R7");
        stall("R7");
        adv_cyc(4'h6, "R7");
        adv_cyc(4'hF, "R7");
        load(0, 8'h60, 4'h0, "R7");
        repeat (2) stall("R7");
        adv_cyc(4'h0, "R7");
        adv_cyc(4'h0, "R7");
        stall("R7");
        desel("R7");
        stall("R7");
        repeat (3) desel("R9");

        // R6: unselected loads and advances must not write
        i_cen = 1; i_adv = 0; i_csa = 1; i_csb = 0; i_csc = 1; i_wr = 1; i_addr = 8'h70; i_be = 4'hF;
        tick("R6");
        adv_cyc(4'hF, "R6"); adv_cyc(4'hF, "R6");
        i_cen = 1; i_adv = 0; i_csa = 0; i_csb = 1; i_csc = 1; i_wr = 1; i_addr = 8'h74; i_be = 4'hF;
        tick("R6");
        adv_cyc(4'hF, "R6");
        i_cen = 1; i_adv = 0; i_csa = 0; i_csb = 0; i_csc = 0; i_wr = 1; i_addr = 8'h71; i_be = 4'hF;
        tick("R6");
        adv_cyc(4'hF, "R6");
        load(0, 8'h70, 4'h0, "R6");
        repeat (3) adv_cyc(4'h0, "R6");
        load(0, 8'h74, 4'h0, "R6");
        repeat (3) desel("R6");

        // Random mix of every command kind
        for (int n = 0; n < 4000; n++) begin
            i_cen = ($urandom % 8) != 0;
            i_adv = ($urandom % 3) != 0;
            i_wr  = $urandom;
            i_csa = ($urandom % 8) == 0;
            i_csb = ($urandom % 8) == 0;
            i_csc = ($urandom % 8) != 0;
            i_ilv = $urandom;
            i_addr = ($urandom % 2) ? 8'($urandom % 16) : 8'($urandom);
            i_be = $urandom;
            tick("R8 random");
        end
        repeat (3) desel("R9");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule